// File: doc/BRIEF.md
# SPI Slave to Parallel Memory Bus Bridge

This block lets an SPI master reach a passive parallel device, such as a small RAM or a display controller, without any command protocol. The master lowers the select line and shifts in one address word, most significant bit first. From then on each further word is a full-duplex exchange. The master receives the contents of the current location on the slave output. The word it sends in the same slot is written back to that location. The address then advances by one. Raising the select line ends the transaction.

The serial inputs are sampled by the system clock through two-flop synchronizers, and serial clock edges are found by comparing successive synchronized values. Two static pins choose the clock idle level and whether bits are captured on the first or the second edge of each bit period. The read strobe and the write enable are single-cycle pulses. The read data input is captured at the end of the read strobe cycle, so the device must present the addressed word during that cycle.

Top module: `spi_mem_bridge`

## Requirements
- R1: While reset is asserted and after it is released, `bus_addr`, `bus_wdata`, `bus_rd` and `bus_we` are zero, and `spi_miso` is 0 while no transfer is active.
- R2: The first ADDR_W bits received after `spi_sel_n` falls, MSB first, are loaded into `bus_addr`. One system clock later `bus_rd` pulses for one cycle.
- R3: The value on `bus_rdata` during a `bus_rd` cycle is shifted out on `spi_miso`, MSB first, during the next data word of the transfer. During the address word `spi_miso` carries zeros.
- R4: When a data word of DATA_W bits has been received, MSB first, it appears on `bus_wdata` and `bus_we` pulses for exactly one cycle while `bus_addr` still holds the address of that word.
- R5: In the cycle after `bus_we`, `bus_addr` holds the previous address plus one, wrapping modulo 2^ADDR_W, and `bus_rd` pulses. `bus_rd` and `bus_we` are never high together.
- R6: `cpol` = 0 means the clock idles low and `cpol` = 1 means it idles high. `cpha` = 0 captures `spi_mosi` on the first edge of each bit and updates `spi_miso` on the second edge. `cpha` = 1 updates `spi_miso` on the first edge and captures on the second. All four combinations move the same data. Each clock level must last at least two system clocks.
- R7: If `spi_sel_n` rises before a word is complete, the partial word is dropped. No strobe is issued, `bus_addr` and `bus_wdata` keep their values, and the next transfer starts again with an address word.
- R8: `spi_miso` is 0 whenever `spi_sel_n` is high, starting in the same cycle that it rises.
- R9: The address word length and the data word length are set separately by ADDR_W (default 10) and DATA_W (default 8). After a transfer of n complete data words starting at address A, `bus_addr` equals A + n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Capture on first (0) or second (1) edge of each bit |
| spi_sck | input | 1 | Serial clock from master |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| bus_addr | output | ADDR_W | Parallel address |
| bus_wdata | output | DATA_W | Parallel write data |
| bus_rdata | input | DATA_W | Parallel read data |
| bus_rd | output | 1 | Read strobe, one cycle |
| bus_we | output | 1 | Write enable, one cycle |

## Verification
On every cycle the assertions check the strobe discipline. They check that read and write never overlap, that each strobe lasts one cycle, and that a write is followed at once by a read. They also check that the address moves only by a loaded address word or by an increment of one after a write. What only the bench scenarios can show is the content of the exchange: the captured address and data bits in all four clock modes, the read word arriving on the serial output in the correct slot, and address wrap at the top of the space. The bench also shows that a transfer cut off in the address word or in a data word leaves no trace on the bus.

// File: rtl/spibr_pkg.sv
package spibr_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WR   = 2'd1,
    SQ_RD   = 2'd2
  } seq_t;

  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spibr_rstsync.sv
module spibr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_sync_n = chain_q[1];
endmodule

// File: rtl/spibr_sync.sv
module spibr_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/spibr_edge.sv
module spibr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cpol,
  input  logic cpha,
  input  logic active,
  output logic sample_p,
  output logic shift_p
);
  logic norm, prev_q;
  logic lead, trail;

  // clock normalised so that its idle level is always 0
  assign norm = sck_s ^ cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= norm;
  end

  assign lead  = norm & ~prev_q;
  assign trail = ~norm & prev_q;

  assign sample_p = active & (cpha ? trail : lead);
  assign shift_p  = active & (cpha ? lead  : trail);
endmodule

// File: rtl/spibr_shift.sv
module spibr_shift #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RX_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample_p,
  input  logic              shift_p,
  input  logic              si_bit,
  input  logic              arm_skip,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] load_val,
  output logic [RX_W-1:0]   rx_word,
  output logic              so_bit
);
  logic [RX_W-1:0]   rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              skip_q, skip_d;

  assign rx_word = {rx_q[RX_W-2:0], si_bit};
  assign so_bit  = tx_q[DATA_W-1];

  always_comb begin
    rx_d   = rx_q;
    tx_d   = tx_q;
    skip_d = skip_q;
    if (clr) begin
      rx_d   = '0;
      tx_d   = '0;
      skip_d = 1'b0;
    end else begin
      if (sample_p) rx_d = rx_word;
      // the first shift edge after a word boundary keeps the new MSB in place
      if (shift_p) begin
        if (skip_q) skip_d = 1'b0;
        else        tx_d   = {tx_q[DATA_W-2:0], 1'b0};
      end
      if (arm_skip) skip_d = 1'b1;
      if (load_tx)  tx_d   = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      skip_q <= skip_d;
    end
  end
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge
  import spibr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              spi_sck,
  input  logic              spi_sel_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_we
);
  localparam int unsigned RX_W  = wmax(ADDR_W, DATA_W);
  localparam int unsigned CNT_W = $clog2(RX_W);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic rst_i_n;
  logic sck_s, sel_s, mosi_s;
  logic sample_p, shift_p;
  logic [RX_W-1:0] rx_word;
  logic so_bit;

  spibr_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  spibr_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_i_n),
    .d    ({spi_sck, spi_sel_n, spi_mosi}),
    .q    ({sck_s, sel_s, mosi_s})
  );

  spibr_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .sck_s   (sck_s),
    .cpol    (cpol),
    .cpha    (cpha),
    .active  (~sel_s),
    .sample_p(sample_p),
    .shift_p (shift_p)
  );

  // sequencer state
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              aph_q, aph_d;
  seq_t              seq_q, seq_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic [DATA_W-1:0] wdat_q;
  logic              wdat_en;
  logic              word_done;

  assign word_done = sample_p && (bit_q == (aph_q ? ADDR_LAST : DATA_LAST));

  spibr_shift #(.DATA_W(DATA_W), .RX_W(RX_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (sel_s),
    .sample_p(sample_p),
    .shift_p (shift_p),
    .si_bit  (mosi_s),
    .arm_skip(word_done),
    .load_tx (seq_q == SQ_RD),
    .load_val(bus_rdata),
    .rx_word (rx_word),
    .so_bit  (so_bit)
  );

  always_comb begin
    bit_d   = bit_q;
    aph_d   = aph_q;
    seq_d   = seq_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    wdat_en = 1'b0;

    if (sel_s) begin
      bit_d = '0;
      aph_d = 1'b1;
    end else if (sample_p) begin
      bit_d = word_done ? '0 : bit_q + 1'b1;
      if (word_done) aph_d = 1'b0;
    end

    unique case (seq_q)
      SQ_IDLE: if (word_done) seq_d = aph_q ? SQ_RD : SQ_WR;
      SQ_WR:   seq_d = SQ_RD;
      SQ_RD:   seq_d = SQ_IDLE;
      default: seq_d = SQ_IDLE;
    endcase

    if (word_done && aph_q) begin
      addr_d  = rx_word[ADDR_W-1:0];
      addr_en = 1'b1;
    end else if (seq_q == SQ_WR) begin
      addr_d  = addr_q + 1'b1;
      addr_en = 1'b1;
    end

    if (word_done && !aph_q) wdat_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bit_q  <= '0;
      aph_q  <= 1'b1;
      seq_q  <= SQ_IDLE;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      bit_q <= bit_d;
      aph_q <= aph_d;
      seq_q <= seq_d;
      if (addr_en) addr_q <= addr_d;
      if (wdat_en) wdat_q <= rx_word[DATA_W-1:0];
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = wdat_q;
  assign bus_rd    = (seq_q == SQ_RD);
  assign bus_we    = (seq_q == SQ_WR);
  assign spi_miso  = ~spi_sel_n & ~sel_s & so_bit;

  // R5
  rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(bus_rd && bus_we));

  // R5
  we_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_we |=> bus_rd);

  // R5
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_we |=> (bus_addr == $past(bus_addr) + 1'b1));

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_we |=> !bus_we);

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_rd |=> !bus_rd);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_we |=> ((bus_addr == $past(bus_addr)) || bus_rd));
endmodule

// File: tb/tb_spi_mem_bridge.sv
module tb_spi_mem_bridge;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int H  = 8;

  typedef struct packed {
    logic          is_wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0;
  logic sck = 1'b0, sel_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rd, we;

  int nchecks = 0;
  int errors  = 0;
  int cyc     = 0;
  bit done    = 1'b0;
  ev_t q[$];

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return (a[7:0] ^ 8'h5A) + {6'b0, a[9:8]};
  endfunction

  function automatic logic [DW-1:0] wr_val(input logic [AW-1:0] a, input int k);
    return 8'hC3 ^ 8'(k * 29) ^ a[7:0];
  endfunction

  assign rdata = mem_val(addr);

  spi_mem_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
    .spi_sck(sck), .spi_sel_n(sel_n), .spi_mosi(mosi), .spi_miso(miso),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_rd(rd), .bus_we(we)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares every strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && (rd || we)) begin
      if (q.size() == 0) begin
        chk("R7", "unexpected strobe", {30'b0, rd, we}, 32'h0);
      end else begin
        ev_t e;
        e = q.pop_front();
        if (we) begin
          chk("R4", "write expected", {31'b0, e.is_wr}, 32'h1);
          chk("R4", "write address", {22'b0, addr}, {22'b0, e.a});
          chk("R4", "write data", {24'b0, wdata}, {24'b0, e.d});
        end else begin
          chk("R5", "read expected", {31'b0, e.is_wr}, 32'h0);
          chk("R2", "read address", {22'b0, addr}, {22'b0, e.a});
        end
      end
    end
  end

  task automatic set_mode(input logic p, input logic h);
    @(negedge clk);
    cpol = p; cpha = h; sck = p;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_bit(input logic mo, output logic mi);
    if (!cpha) mosi = mo;
    repeat (H) @(negedge clk);
    if (!cpha) mi = miso;
    sck = ~sck;
    if (cpha) mosi = mo;
    repeat (H) @(negedge clk);
    if (cpha) mi = miso;
    sck = ~sck;
  endtask

  task automatic end_xfer();
    repeat (H) @(negedge clk);
    sel_n = 1'b1;
    #1;
    chk("R8", "miso low as select rises", {31'b0, miso}, 32'h0);
    repeat (12) @(negedge clk);
    chk("R7", "no pending bus events", q.size(), 32'h0);
    chk("R8", "miso low while idle", {31'b0, miso}, 32'h0);
  endtask

  // full transfer: n words, then optional partial word of pbits bits
  task automatic xfer(input logic [AW-1:0] a, input int n, input int pbits);
    logic mi;
    logic [DW-1:0] got, d;
    logic [AW-1:0] zero_chk;
    @(negedge clk);
    sel_n = 1'b0;
    q.push_back('{1'b0, a, '0});
    zero_chk = '0;
    for (int i = AW - 1; i >= 0; i--) begin
      do_bit(a[i], mi);
      zero_chk[i] = mi;
    end
    chk("R3", "miso zero in address word", {22'b0, zero_chk}, 32'h0);
    for (int k = 0; k < n; k++) begin
      d = wr_val(a, k);
      q.push_back('{1'b1, a + AW'(k), d});
      q.push_back('{1'b0, a + AW'(k + 1), '0});
      for (int i = DW - 1; i >= 0; i--) begin
        do_bit(d[i], mi);
        got[i] = mi;
      end
      chk("R3", "serial read word", {24'b0, got}, {24'b0, mem_val(a + AW'(k))});
    end
    for (int i = 0; i < pbits; i++) do_bit(1'b1, mi);
    end_xfer();
    chk("R9", "address after transfer", {22'b0, addr}, {22'b0, a + AW'(n)});
  endtask

  task automatic addr_abort(input logic [AW-1:0] a, input int bits);
    logic mi;
    @(negedge clk);
    sel_n = 1'b0;
    for (int i = AW - 1; i > AW - 1 - bits; i--) do_bit(a[i], mi);
    end_xfer();
  endtask

  initial begin
    logic [AW-1:0] a_keep;
    logic [DW-1:0] d_keep;
    repeat (3) @(negedge clk);
    // R1: values during reset and after release
    chk("R1", "addr in reset", {22'b0, addr}, 32'h0);
    chk("R1", "rd in reset", {31'b0, rd}, 32'h0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1", "addr after reset", {22'b0, addr}, 32'h0);
    chk("R1", "wdata after reset", {24'b0, wdata}, 32'h0);
    chk("R1", "strobes after reset", {30'b0, rd, we}, 32'h0);
    chk("R1", "miso after reset", {31'b0, miso}, 32'h0);

    // R6: all four clock modes; R9: full 10-bit address
    set_mode(1'b0, 1'b0); xfer(10'h2F3, 3, 0);
    set_mode(1'b0, 1'b1); xfer(10'h015, 2, 0);
    // R5: wrap at the top of the address space
    set_mode(1'b1, 1'b0); xfer(10'h3FE, 3, 0);
    chk("R5", "address wrapped", {22'b0, addr}, 32'h001);
    set_mode(1'b1, 1'b1); xfer(10'h100, 2, 0);
    chk("R6", "mode 3 last write data", {24'b0, wdata}, {24'b0, wr_val(10'h100, 1)});

    // R7: abort inside address word
    a_keep = addr; d_keep = wdata;
    set_mode(1'b0, 1'b0);
    addr_abort(10'h1AA, 5);
    chk("R7", "addr unchanged after address abort", {22'b0, addr}, {22'b0, a_keep});
    chk("R7", "wdata unchanged after address abort", {24'b0, wdata}, {24'b0, d_keep});

    // R7: abort inside a data word
    xfer(10'h0A0, 1, 3);
    chk("R7", "wdata holds last full word", {24'b0, wdata}, {24'b0, wr_val(10'h0A0, 0)});
    // R7: next transfer begins with an address again
    set_mode(1'b0, 1'b1);
    addr_abort(10'h000, 7);
    xfer(10'h055, 1, 0);
    chk("R7", "restart after abort", {22'b0, addr}, 32'h056);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1'b1;
      errors++;
      nchecks++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, nchecks);
      $finish;
    end
  end
endmodule